// File: doc/BRIEF.md
# Bidirectional GPIO Port Register Bank

This block is the register bank of a 16-pin general-purpose I/O expander, organised as two 8-bit ports. A simple register port addressed by a 3-bit index reaches four register pairs: sampled input levels, output values, read-data polarity inversion and pin direction. The bank drives a level and an enable for every pin, and it samples the pin levels through a two-flop synchronizer.

A host writes a direction bit of 0 to turn a pin into an output. The pin then carries the stored output bit. A direction bit of 1 turns the pin into an input with its driver released. Input reads return the synchronized pin levels, with each bit inverted where its polarity bit is set. Output-register reads return the stored value, whatever level the pin shows. A synchronous reset sets the bank to the power-up state: all pins are inputs, the output registers hold ones and the polarity registers hold zeros.

Top module: `gpio_reg_bank`

## Requirements
- R1: While `rst` is high at a rising edge, the bank loads its reset state: direction registers 0xFF, output registers 0xFF, polarity registers 0x00 and `rdData` 0x00. After reset every `pinOe` bit is 0 and every `pinOut` bit is 0.
- R2: Index 6 holds the direction of port 0 (pins 7..0) and index 7 holds the direction of port 1 (pins 15..8). Bit value 1 means input and 0 means output. Each `pinOe` bit is the inverse of its direction bit and takes the new value on the edge that samples the write.
- R3: A `pinOut` bit equals its output-register bit while the pin is an output, and is 0 while the pin is an input. Index 2 holds the output register of port 0 and index 3 holds that of port 1.
- R4: A read of index 2 or 3 returns the stored output register, independent of `pinIn` and of the direction bits.
- R5: A read of index 0 (port 0) or index 1 (port 1) returns the pin levels through a two-flop synchronizer. A `pinIn` change set up before rising edge k shows in a read sampled at edge k+2, and does not show in a read sampled at edge k+1.
- R6: Index 4 (port 0) and index 5 (port 1) hold the polarity bits. A polarity bit of 1 inverts the matching input read bit, and a bit of 0 passes it unchanged.
- R7: Writes to index 0 or 1 have no effect. They change no pin, no register and no input read value.
- R8: A write changes only the 8-bit register it addresses. The other port's register of the same pair is unchanged.
- R9: `rdData` is loaded on the rising edge that samples `rdEn` high and holds its value otherwise. When a read and a write to the same index are sampled on the same edge, the read returns the value from before the write.
- R10: A read of index 4..7 returns the stored polarity or direction register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| regAddr | input | 3 | Register index 0..7 |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| pinIn | input | 16 | Pin levels seen at the pads |
| pinOut | output | 16 | Pin output levels |
| pinOe | output | 16 | Pin output enables, 1 drives the pin |

## Verification
A read and a write can fall in the same cycle. Two cases matter here: a read of the polarity register while it is being rewritten, and back-to-back input reads that straddle a pin change which is still crossing the synchronizer. The first case is provoked by raising `wrEn` and `rdEn` together on index 5. It passes only if the old register value comes back and the new value appears on the next read. The second case is judged by the scoreboard. It expects the old pin level from the read sampled one edge after the change, and the new level, after inversion, from the read sampled one edge later.

// File: rtl/gpio_reg_pkg.sv
package gpio_reg_pkg;
  localparam int NUM_PORTS = 2;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    GRP_IN  = 2'd0,
    GRP_OUT = 2'd1,
    GRP_POL = 2'd2,
    GRP_CFG = 2'd3
  } regGroup_e;

  typedef struct packed {
    logic [NUM_PORTS-1:0] wrOut;
    logic [NUM_PORTS-1:0] wrPol;
    logic [NUM_PORTS-1:0] wrCfg;
    logic                 rdGo;
    regGroup_e            rdGrp;
    logic                 rdPort;
  } bankStrobe_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= asyncIn;
      stage2 <= stage1;
    end
  end

  assign syncOut = stage2;
endmodule

// File: rtl/gpio_reg_ctrl.sv
module gpio_reg_ctrl
  import gpio_reg_pkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output bankStrobe_t       strobe
);
  regGroup_e grp;
  logic      portSel;

  assign grp     = regGroup_e'(regAddr[ADDR_W-1:1]);
  assign portSel = regAddr[0];

  always_comb begin
    strobe        = '0;
    strobe.rdGo   = rdEn;
    strobe.rdGrp  = grp;
    strobe.rdPort = portSel;
    if (wrEn) begin
      unique case (grp)
        GRP_OUT: strobe.wrOut[portSel] = 1'b1;
        GRP_POL: strobe.wrPol[portSel] = 1'b1;
        GRP_CFG: strobe.wrCfg[portSel] = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_reg_dp.sv
module gpio_reg_dp
  import gpio_reg_pkg::*;
#(
  parameter int PORT_W = 8,
  localparam int PIN_W = PORT_W * NUM_PORTS
) (
  input  logic              clk,
  input  logic              rst,
  input  bankStrobe_t       strobe,
  input  logic [PORT_W-1:0] wrData,
  input  logic [PIN_W-1:0]  pinIn,
  output logic [PORT_W-1:0] rdData,
  output logic [PIN_W-1:0]  pinOut,
  output logic [PIN_W-1:0]  pinOe
);
  logic [PORT_W-1:0] outReg [NUM_PORTS];
  logic [PORT_W-1:0] polReg [NUM_PORTS];
  logic [PORT_W-1:0] cfgReg [NUM_PORTS];
  logic [PORT_W-1:0] inView [NUM_PORTS];
  logic [PIN_W-1:0]  pinSync;
  logic [PORT_W-1:0] rdNext;

  gpio_sync #(.WIDTH(PIN_W)) i_sync (
    .clk(clk), .rst(rst), .asyncIn(pinIn), .syncOut(pinSync)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) begin
        outReg[p] <= '1;
        polReg[p] <= '0;
        cfgReg[p] <= '1;
      end else begin
        if (strobe.wrOut[p]) outReg[p] <= wrData;
        if (strobe.wrPol[p]) polReg[p] <= wrData;
        if (strobe.wrCfg[p]) cfgReg[p] <= wrData;
      end
    end

    assign inView[p]                   = pinSync[p*PORT_W +: PORT_W] ^ polReg[p];
    assign pinOe[p*PORT_W +: PORT_W]   = ~cfgReg[p];
    assign pinOut[p*PORT_W +: PORT_W]  = outReg[p] & ~cfgReg[p];
  end

  always_comb begin
    unique case (strobe.rdGrp)
      GRP_IN:  rdNext = inView[strobe.rdPort];
      GRP_OUT: rdNext = outReg[strobe.rdPort];
      GRP_POL: rdNext = polReg[strobe.rdPort];
      default: rdNext = cfgReg[strobe.rdPort];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)              rdData <= '0;
    else if (strobe.rdGo) rdData <= rdNext;
  end
endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
  import gpio_reg_pkg::*;
#(
  parameter int PORT_W = 8,
  localparam int PIN_W = PORT_W * NUM_PORTS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [PORT_W-1:0] wrData,
  output logic [PORT_W-1:0] rdData,
  input  logic [PIN_W-1:0]  pinIn,
  output logic [PIN_W-1:0]  pinOut,
  output logic [PIN_W-1:0]  pinOe
);
  bankStrobe_t strobe;

  gpio_reg_ctrl i_ctrl (
    .wrEn(wrEn), .rdEn(rdEn), .regAddr(regAddr), .strobe(strobe)
  );

  gpio_reg_dp #(.PORT_W(PORT_W)) i_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .wrData(wrData),
    .pinIn(pinIn), .rdData(rdData), .pinOut(pinOut), .pinOe(pinOe)
  );
endmodule

// File: rtl/gpio_reg_chk.sv
module gpio_reg_chk
  import gpio_reg_pkg::*;
#(
  parameter int PORT_W = 8,
  localparam int PIN_W = PORT_W * NUM_PORTS
) (
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [PORT_W-1:0] wrData,
  input logic [PORT_W-1:0] rdData,
  input logic [PIN_W-1:0]  pinOut,
  input logic [PIN_W-1:0]  pinOe
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pinOe == '0) && (pinOut == '0) && (rdData == '0));

  // R2
  dir_port0_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && regAddr == 3'd6) |=> pinOe[PORT_W-1:0] == ~$past(wrData));

  // R2
  dir_port1_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && regAddr == 3'd7) |=> pinOe[PIN_W-1:PORT_W] == ~$past(wrData));

  // R3
  input_pin_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (pinOut & ~pinOe) == '0);

  // R7
  input_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && regAddr[2:1] == 2'd0) |=> $stable(pinOe) && $stable(pinOut));

  // R8
  port0_write_isolated_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !regAddr[0]) |=> $stable(pinOe[PIN_W-1:PORT_W]) && $stable(pinOut[PIN_W-1:PORT_W]));

  // R8
  port1_write_isolated_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && regAddr[0]) |=> $stable(pinOe[PORT_W-1:0]) && $stable(pinOut[PORT_W-1:0]));

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rdEn |=> $stable(rdData));
endmodule

bind gpio_reg_bank gpio_reg_chk #(.PORT_W(PORT_W)) i_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .regAddr(regAddr),
  .wrData(wrData), .rdData(rdData), .pinOut(pinOut), .pinOe(pinOe)
);

// File: tb/test_gpio_reg_bank.sv
module test_gpio_reg_bank;
  logic        clk = 1'b0;
  logic        rst;
  logic        wrEn;
  logic        rdEn;
  logic [2:0]  regAddr;
  logic [7:0]  wrData;
  logic [7:0]  rdData;
  logic [15:0] pinIn;
  logic [15:0] pinOut;
  logic [15:0] pinOe;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  logic rdSampled = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } rdItem_t;
  rdItem_t expQ[$];

  always #2 clk = ~clk;

  gpio_reg_bank i_gpio_reg_bank (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );

  always @(posedge clk) rdSampled <= rdEn;

  // monitor: compares each sampled read against the scoreboard
  always @(negedge clk) begin
    if (rdSampled) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL read with no expected item: rdData=%h", rdData);
      end else begin
        rdItem_t it;
        it = expQ.pop_front();
        if (rdData !== it.exp) begin
          fails++;
          $display("FAIL %s: rdData=%h expected %h", it.tag, rdData, it.exp);
        end
      end
    end
  end

  task automatic checkVal(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected %h", tag, act, exp);
    end
  endtask

  // drivers assume they start at a falling edge
  task automatic doWrite(logic [2:0] a, logic [7:0] d);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(logic [2:0] a, logic [7:0] exp, string tag);
    rdEn = 1'b1; regAddr = a;
    expQ.push_back('{exp, tag});
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wrEn = 1'b0; rdEn = 1'b0; regAddr = '0; wrData = '0; pinIn = '0;
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    checkVal("R1 pinOe", pinOe, 16'h0000);
    checkVal("R1 pinOut", pinOut, 16'h0000);
    checkVal("R1 rdData", {8'h00, rdData}, 16'h0000);
    doRead(3'd2, 8'hFF, "R1 out0");
    doRead(3'd3, 8'hFF, "R1 out1");
    doRead(3'd4, 8'h00, "R1 pol0");
    doRead(3'd5, 8'h00, "R1 pol1");
    doRead(3'd6, 8'hFF, "R1 cfg0");
    doRead(3'd7, 8'hFF, "R1 cfg1");

    // R2 / R3 direction and output drive
    doWrite(3'd6, 8'h0F);
    checkVal("R2 pinOe after cfg0", pinOe, 16'h00F0);
    checkVal("R3 pinOut after cfg0", pinOut, 16'h00F0);
    doWrite(3'd2, 8'hA5);
    checkVal("R3 pinOut after out0", pinOut, 16'h00A0);
    doRead(3'd2, 8'hA5, "R4 out0 stored");
    doRead(3'd6, 8'h0F, "R10 cfg0");

    // R8 per-port independence
    doWrite(3'd7, 8'h00);
    checkVal("R2 pinOe after cfg1", pinOe, 16'hFFF0);
    doWrite(3'd3, 8'h3C);
    checkVal("R8 pinOut port1 set, port0 kept", pinOut, 16'h3CA0);
    doRead(3'd3, 8'h3C, "R8 out1");
    doRead(3'd2, 8'hA5, "R8 out0 kept");
    doRead(3'd6, 8'h0F, "R8 cfg0 kept");

    // R5 input through synchronizer; R4 stored value differs from pins
    pinIn = 16'h1234;
    idle(2);
    doRead(3'd0, 8'h34, "R5 in0");
    doRead(3'd1, 8'h12, "R5 in1");
    doRead(3'd2, 8'hA5, "R4 out0 not pin level");

    // R6 polarity
    doWrite(3'd4, 8'hFF);
    doWrite(3'd5, 8'h0F);
    doRead(3'd0, 8'hCB, "R6 in0 inverted");
    doRead(3'd1, 8'h1D, "R6 in1 low nibble inverted");
    doRead(3'd5, 8'h0F, "R10 pol1");

    // R7 input registers read-only
    doWrite(3'd0, 8'h55);
    doWrite(3'd1, 8'hAA);
    checkVal("R7 pinOe", pinOe, 16'hFFF0);
    checkVal("R7 pinOut", pinOut, 16'h3CA0);
    doRead(3'd0, 8'hCB, "R7 in0");
    doRead(3'd1, 8'h1D, "R7 in1");
    doRead(3'd4, 8'hFF, "R7 pol0");

    // R5 latency boundary: edge k+1 old, edge k+2 new
    pinIn = 16'h0000;
    idle(1);
    doRead(3'd0, 8'hCB, "R5 edge k+1 old");
    doRead(3'd0, 8'hFF, "R5 edge k+2 new");

    // R9 read/write collision and hold
    wrEn = 1'b1; wrData = 8'h77;
    doRead(3'd5, 8'h0F, "R9 collision old value");
    wrEn = 1'b0;
    doRead(3'd5, 8'h77, "R9 new value");
    idle(2);
    checkVal("R9 rdData held", {8'h00, rdData}, 16'h0077);

    // R3 back to input: driver released
    doWrite(3'd6, 8'hFF);
    checkVal("R3 pinOut port0 input", pinOut, 16'h3C00);

    // R1 second reset
    idle(1);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    checkVal("R1 pinOe after reset", pinOe, 16'h0000);
    doRead(3'd7, 8'hFF, "R1 cfg1 after reset");
    doRead(3'd3, 8'hFF, "R1 out1 after reset");
    idle(2);
    if (expQ.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL scoreboard: %0d reads never returned, expected 0", expQ.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule